// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is the two-wire serial slave that a host uses to set up a clock generator. It holds a bank of 8-bit configuration registers. Each stored bit is also driven out in parallel to the synthesizer, divider and output-enable logic. The serial clock and data lines arrive from outside the chip. Each passes through its own synchroniser into the system clock domain. Bus events are found from the synchronised levels: start, stop, and rising and falling clock edges. The slave drives the data line only through an open-drain enable.

The host has two kinds of access. A byte transfer uses the command code as the register index. A block transfer, selected by command code 00h, carries a byte count and then moves registers upward from index 0. The index advances after every data byte. Some bits are read-only: an identification byte and a group of bits that hold board strap levels captured while reset is high. Writes to read-only bits are masked. A test register decodes a key and a mode nibble into three test controls.

Top module: `clkcfg_regslave`

## Requirements
- R1: After reset the parallel outputs hold these defaults: reg0=10h, reg2=FFh, reg3=FFh, reg4=FFh, reg6=24h, reg8=90h, reg9=BBh, reg10=3Bh, reg11=0Eh, reg12=01h, reg13=0Ah, reg14=10h, reg15=2Ch, reg16=24h, reg17=08h, reg18=00h, reg20=88h, reg22=00h. The straps set the remaining bits as R3 states, and sda_oe is low.
- R2: The slave acknowledges an address byte whose upper seven bits equal 69h, so D2h writes and D3h reads. It acknowledges by asserting sda_oe through the ninth clock. Any other address gets no acknowledge, and the transfer that follows leaves every register unchanged.
- R3: Bits 3..0 of reg1 hold strap_fs as sampled during reset. The reset value of reg5 bit 7 is strap_sel24, of reg19 bit 0 is strap_mode, and of reg21 bit 4 is strap_sel12. After reset those three bits can be written.
- R4: reg7 always reads 01h, and writes to it are dropped. reg1 bits 4..0 are read-only, and bit 4 stays 0. The other bits of reg1 can be written.
- R5: A byte write (D2h, command, data) stores the data at the index given by the command. A byte read (D2h, command, repeated start, D3h) returns the register at that index. cfg_o[8*i+7:8*i] always shows register i, and it changes only while the serial clock is low.
- R6: A read that follows command 00h returns the register count first (23, LSB-first weight, MSB sent first on the wire). It then returns reg0, reg1 and upward.
- R7: A write with command 00h treats the next byte as a count and does not store it. The bytes after the count go to reg0, reg1 and upward.
- R8: The index rises by one after each data byte. Write data at index 23 or higher is discarded. A read at index 23 or higher returns 00h.
- R9: In reg22, an upper nibble of 1011b enables test mode. With the key present, a lower nibble of 1000b raises wd_test, 0010b raises force_hi and 0001b raises force_lo. Any other value leaves all three low, so at most one is ever high.
- R10: sda_oe changes only while scl_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap_fs | input | 4 | Frequency-select strap levels |
| strap_sel24 | input | 1 | Strap for the 24/48 MHz select bit |
| strap_mode | input | 1 | Strap for the desktop/mobile select bit |
| strap_sel12 | input | 1 | Strap for the 12/48 MHz select bit |
| cfg_o | output | 184 | All 23 registers, register i in bits 8i+7..8i |
| wd_test | output | 1 | Watchdog test mode decoded from reg22 |
| force_hi | output | 1 | Force-high test mode decoded from reg22 |
| force_lo | output | 1 | Force-low test mode decoded from reg22 |

## Verification
A single byte of a block write can land on a read-only bit and also step the index past the top of the bank. Read-only masking and the out-of-range discard then act on the same stream of bytes. The bench provokes both with one 25-data-byte block write from index 0. That write crosses reg1 and reg7 and runs two bytes beyond reg22. Every parallel output is then compared against a model that applies the mask to each byte and drops the bytes past the end. A later read that starts near the top shows the index crossing into the 00h region on the wire.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK
  } tw_state_e;

  // Bits that host writes cannot change.
  function automatic logic [7:0] ro_mask(input int idx);
    case (idx)
      1:       ro_mask = 8'h1F;
      7:       ro_mask = 8'hFF;
      default: ro_mask = 8'h00;
    endcase
  endfunction

  // Reset value, with strap-derived bits merged in.
  function automatic logic [7:0] reset_value(input int idx, input logic [3:0] fs,
                                             input logic s24, input logic smode,
                                             input logic s12);
    case (idx)
      0:  reset_value = 8'h10;
      1:  reset_value = {4'hE, fs};
      2:  reset_value = 8'hFF;
      3:  reset_value = 8'hFF;
      4:  reset_value = 8'hFF;
      5:  reset_value = {s24, 7'h00};
      6:  reset_value = 8'h24;
      7:  reset_value = 8'h01;
      8:  reset_value = 8'h90;
      9:  reset_value = 8'hBB;
      10: reset_value = 8'h3B;
      11: reset_value = 8'h0E;
      12: reset_value = 8'h01;
      13: reset_value = 8'h0A;
      14: reset_value = 8'h10;
      15: reset_value = 8'h2C;
      16: reset_value = 8'h24;
      17: reset_value = 8'h08;
      18: reset_value = 8'h00;
      19: reset_value = {7'b1101101, smode};
      20: reset_value = 8'h88;
      21: reset_value = {3'b000, s12, 4'h0};
      default: reset_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // One extra stage beyond the synchroniser keeps the previous level.
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;
  logic scl_now, scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_now  = scl_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_s    = sda_sh[STAGES-1];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  assign start_ev = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 23
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  input  logic [7:0] rd_data
);
  localparam logic [7:0] NREG_B = 8'(NREG);
  localparam logic [3:0] LAST   = 4'd8;

  tw_state_e  state;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [7:0] ptr;
  logic       rw_q, cmd_next, cnt_next, blk_q, cnt_pend, nack_q;
  logic [7:0] tx;

  assign tx     = cnt_pend ? NREG_B : rd_data;
  assign rd_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      cmd_next <= 1'b0;
      cnt_next <= 1'b0;
      blk_q    <= 1'b0;
      cnt_pend <= 1'b0;
      nack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && bitcnt != LAST) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST) begin
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  rw_q     <= sh[0];
                  cmd_next <= ~sh[0];
                  cnt_next <= 1'b0;
                  cnt_pend <= sh[0] & blk_q;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (cmd_next) begin
                  ptr      <= sh;
                  blk_q    <= (sh == 8'h00);
                  cnt_next <= (sh == 8'h00);
                  cmd_next <= 1'b0;
                end else if (cnt_next) begin
                  cnt_next <= 1'b0;
                end else begin
                  wr_en   <= (ptr < NREG_B);
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                sh       <= tx;
                sda_oe   <= ~tx[7];
                cnt_pend <= 1'b0;
                if (!cnt_pend && ptr != 8'hFF) ptr <= ptr + 8'd1;
                state    <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                bitcnt   <= '0;
                sh       <= tx;
                sda_oe   <= ~tx[7];
                cnt_pend <= 1'b0;
                if (!cnt_pend && ptr != 8'hFF) ptr <= ptr + 8'd1;
                state    <= ST_RD;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int NREG     = 23,
  parameter int TEST_IDX = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      strap_fs,
  input  logic            strap_sel24,
  input  logic            strap_mode,
  input  logic            strap_sel12,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] cfg_o,
  output logic            wd_test,
  output logic            force_hi,
  output logic            force_lo
);
  localparam int         IW     = $clog2(NREG);
  localparam logic [7:0] NREG_B = 8'(NREG);
  localparam logic [3:0] KEY    = 4'b1011;

  logic [7:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] RO = ro_mask(i);
    logic [7:0] q;
    logic [7:0] rst_val;
    always_comb rst_val = reset_value(i, strap_fs, strap_sel24, strap_mode, strap_sel12);
    always_ff @(posedge clk) begin
      if (rst)
        q <= rst_val;
      else if (wr_en && wr_idx == 8'(i))
        q <= (q & RO) | (wr_data & ~RO);
    end
    assign view[i]        = q;
    assign cfg_o[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx < NREG_B) rd_data = view[rd_idx[IW-1:0]];
  end

  logic [7:0] tq;
  assign tq = view[TEST_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_test  <= 1'b0;
      force_hi <= 1'b0;
      force_lo <= 1'b0;
    end else begin
      wd_test  <= (tq[7:4] == KEY) && (tq[3:0] == 4'b1000);
      force_hi <= (tq[7:4] == KEY) && (tq[3:0] == 4'b0010);
      force_lo <= (tq[7:4] == KEY) && (tq[3:0] == 4'b0001);
    end
  end
endmodule

// File: rtl/clkcfg_regslave.sv
module clkcfg_regslave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 23,
  parameter int         TEST_IDX    = 22,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        strap_fs,
  input  logic              strap_sel24,
  input  logic              strap_mode,
  input  logic              strap_sel12,
  output logic [NREG*8-1:0] cfg_o,
  output logic              wd_test,
  output logic              force_hi,
  output logic              force_lo
);
  logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tw_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  cfg_regbank #(.NREG(NREG), .TEST_IDX(TEST_IDX)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .strap_fs    (strap_fs),
    .strap_sel24 (strap_sel24),
    .strap_mode  (strap_mode),
    .strap_sel12 (strap_sel12),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .cfg_o       (cfg_o),
    .wd_test     (wd_test),
    .force_hi    (force_hi),
    .force_lo    (force_lo)
  );
endmodule

// File: rtl/clkcfg_regslave_chk.sv
module clkcfg_regslave_chk #(
  parameter int NREG = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_o,
  input logic              wd_test,
  input logic              force_hi,
  input logic              force_lo
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R5
  cfg_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cfg_o)) |-> !scl_i);

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_o[8 +: 5]));

  // R4
  id_value_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_o[56 +: 8] == 8'h01);

  // R9
  test_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wd_test, force_hi, force_lo}));

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o[7:0] == 8'h10 && cfg_o[160 +: 8] == 8'h88 && !sda_oe));
endmodule

bind clkcfg_regslave clkcfg_regslave_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .cfg_o    (cfg_o),
  .wd_test  (wd_test),
  .force_hi (force_hi),
  .force_lo (force_lo)
);

// File: tb/clkcfg_regslave_tb.sv
module clkcfg_regslave_tb;
  localparam int NREG = 23;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] s_fs = 4'hA;
  logic s24 = 1'b1, smode = 1'b0, s12 = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_o;
  logic wd_test, force_hi, force_lo;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  clkcfg_regslave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_fs(s_fs), .strap_sel24(s24), .strap_mode(smode), .strap_sel12(s12),
    .cfg_o(cfg_o), .wd_test(wd_test), .force_hi(force_hi), .force_lo(force_lo)
  );

  int total = 0;
  int bad = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  logic [7:0] expv [NREG];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic prev_oe = 1'b0;

  // R10 monitor: sda_oe may only move while scl is low
  always @(negedge clk) begin
    if (!rst && sda_oe !== prev_oe && scl) oe_viol++;
    prev_oe = sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] romask(input int i);
    return (i == 1) ? 8'h1F : (i == 7) ? 8'hFF : 8'h00;
  endfunction

  task automatic build_defaults();
    expv = '{8'h10, {4'hE, s_fs}, 8'hFF, 8'hFF, 8'hFF, {s24, 7'h00}, 8'h24, 8'h01,
             8'h90, 8'hBB, 8'h3B, 8'h0E, 8'h01, 8'h0A, 8'h10, 8'h2C, 8'h24, 8'h08,
             8'h00, {7'b1101101, smode}, 8'h88, {3'b000, s12, 4'h0}, 8'h00};
  endtask

  task automatic do_reset();
    rst = 1'b1; scl = 1'b1; sda_m = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(3);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic get_byte(input bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = last; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    bus_start();
    put_byte(8'hD2, a); all_ack &= a;
    put_byte(cmd, a);   all_ack &= a;
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a); all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, input int n);
    bit a;
    bus_start();
    put_byte(8'hD2, a);
    put_byte(cmd, a);
    bus_start();
    put_byte(8'hD3, a);
    for (int k = 0; k < n; k++) get_byte(k == n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] cmd, input int n);
    int idx = (cmd == 8'h00) ? 0 : int'(cmd);
    int first = (cmd == 8'h00) ? 1 : 0;
    for (int k = first; k < n; k++) begin
      if (idx < NREG) expv[idx] = (expv[idx] & romask(idx)) | (wbuf[k] & ~romask(idx));
      idx++;
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, cfg_o[i*8 +: 8], expv[i]);
  endtask

  initial begin
    bit ack;
    bit aa;
    do_reset();
    build_defaults();
    // R1 reset state, R3 strap bits
    check_all("R1 reset defaults");
    chk("R1 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    chk("R3 reg1 strap", cfg_o[8 +: 8], 8'hEA);
    chk("R3 reg5/19/21 straps", {cfg_o[47], cfg_o[152], cfg_o[172], 5'b0}, 8'b10100000);

    // R5 byte read sweep
    for (int i = 1; i < NREG; i++) begin
      do_read(8'(i), 1);
      chk($sformatf("R5 byte read reg%0d", i), rbuf[0], expv[i]);
    end

    // R6 block read
    do_read(8'h00, NREG + 1);
    chk("R6 block count", rbuf[0], 8'(NREG));
    for (int i = 0; i < NREG; i++) chk("R6 block data", rbuf[i+1], expv[i]);

    // R2 address match
    bus_start(); put_byte(8'hD4, ack); bus_stop();
    chk("R2 no ack other address", {7'b0, ack}, 8'h00);
    bus_start(); put_byte(8'hA4, ack); put_byte(8'h02, aa); put_byte(8'h00, aa); bus_stop();
    chk("R2 foreign write ignored", cfg_o[16 +: 8], 8'hFF);
    wbuf[0] = 8'h55;
    do_write(8'h03, 1, ack);
    model_write(8'h03, 1);
    chk("R2 own address acked", {7'b0, ack}, 8'h01);

    // R5/R4 byte write sweep
    for (int i = 1; i < NREG; i++) begin
      wbuf[0] = 8'(i * 37 + 91);
      do_write(8'(i), 1, aa);
      model_write(8'(i), 1);
    end
    check_all("R5 byte write sweep");
    chk("R4 id untouched", cfg_o[56 +: 8], 8'h01);
    chk("R4 reg1 low bits", cfg_o[8 +: 8], {8'(1*37+91) & 8'hE0} | 8'h0A);
    for (int i = 1; i < NREG; i++) begin
      do_read(8'(i), 1);
      chk("R5 readback", rbuf[0], expv[i]);
    end

    // R7/R8 block write past the top
    wbuf[0] = 8'd25;
    for (int k = 1; k <= 25; k++) wbuf[k] = 8'(k * 13 + 7);
    do_write(8'h00, 26, aa);
    model_write(8'h00, 26);
    check_all("R7 block write");
    do_read(8'h00, NREG + 1);
    for (int i = 0; i < NREG; i++) chk("R7 block readback", rbuf[i+1], expv[i]);

    // R8 auto-increment and out of range
    do_read(8'd21, 4);
    chk("R8 inc reg21", rbuf[0], expv[21]);
    chk("R8 inc reg22", rbuf[1], expv[22]);
    chk("R8 beyond read 1", rbuf[2], 8'h00);
    chk("R8 beyond read 2", rbuf[3], 8'h00);
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; wbuf[2] = 8'h00;
    do_write(8'd20, 3, aa);
    model_write(8'd20, 3);
    wbuf[0] = 8'h77; wbuf[1] = 8'h66;
    do_write(8'd23, 2, aa);
    model_write(8'd23, 2);
    check_all("R8 increment and discard");

    // R9 test mode sweep
    for (int n = 0; n < 16; n++) begin
      wbuf[0] = {4'b1011, 4'(n)};
      do_write(8'd22, 1, aa);
      chk($sformatf("R9 test mode %0d", n), {5'b0, wd_test, force_hi, force_lo},
          {5'b0, n == 8, n == 2, n == 1});
    end
    wbuf[0] = 8'h78;
    do_write(8'd22, 1, aa);
    chk("R9 wrong key", {5'b0, wd_test, force_hi, force_lo}, 8'h00);

    // R3 second strap set, then strap bits writable
    s_fs = 4'h5; s24 = 1'b0; smode = 1'b1; s12 = 1'b0;
    do_reset();
    build_defaults();
    check_all("R3 new straps");
    wbuf[0] = 8'h00;
    do_write(8'd19, 1, aa);
    model_write(8'd19, 1);
    chk("R3 reg19 writable", cfg_o[152 +: 8], expv[19]);

    total++;
    if (oe_viol != 0) begin
      bad++;
      $display("FAIL R10 sda_oe moved while scl high act=%0d exp=0", oe_viol);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule